// File: doc/BRIEF.md
# Multi-Rail Power-On Reset Sequencer

This block supervises three supply rails: core, analog and the I/O bank that carries the configuration pins. Each rail has its own digital "above trip level" input, driven by an analog comparator outside the block. The block turns those three inputs into one active-low main reset and a single-cycle pulse that starts configuration. It also drives an output tri-state control and two sticky diagnostic flags, one for a ramp-time violation and one for an I/O rail dip.

After reset the block waits until all three rails read good. If that does not happen within a ramp budget, it latches a failure and keeps the I/O tri-stated. Once all rails are good it holds the main reset for a release delay, which is long or short depending on a strap input, and then enters user mode.

In user mode a dip on the core or analog rail is treated as a brown-out: it pulls the main reset low again and restarts the whole sequence. The I/O rail never causes a reset. It is only watched during a fixed window that opens when the rails trip, and a dip inside that window is recorded.

Top module: `por_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `por_n`=0, `io_tristate`=1, `config_start`=0, `ramp_fail`=0 and `io_rail_drop`=0. `rst` is synchronous and active high.
- R2: The inputs `rail_ok[0]` (core), `rail_ok[1]` (analog) and `rail_ok[2]` (I/O bank) are each synchronized by two flops. When the last of the three rails goes high before clock edge k, the sequencer leaves the waiting state at edge k+2. `por_n` then rises at edge k+2+LEN, where LEN is `REL_CYC`.
- R3: When `instant_on`=1, LEN is `FAST_CYC` instead of `REL_CYC`.
- R4: `config_start` is high for exactly one cycle, and that cycle is the first cycle in which `por_n` is high.
- R5: The ramp timer counts from reset release. If the three rails are not all seen good by edge `RAMP_CYC`, then `ramp_fail` rises at that edge. A rail seen good at edge `RAMP_CYC` itself still passes. Once set, `ramp_fail` stays set until `rst`, and `por_n` stays low.
- R6: In user mode, a core or analog rail going low before edge k drops `por_n` at edge k+2. The ramp timer then restarts from zero, so a rail that stays low produces `ramp_fail` `RAMP_CYC` edges after `por_n` fell.
- R7: A low `rail_ok[2]` while `por_n` is high never drops `por_n`.
- R8: The I/O window covers the `IOWIN_CYC` edges that follow the edge at which all rails were seen good. A synchronized I/O-rail low sampled inside the window sets `io_rail_drop`. A low sampled after the window has no effect. The flag stays set until `rst`.
- R9: `io_tristate` is always the inverse of `por_n`.
- R10: A core or analog dip during the release delay returns the sequencer to the waiting state. The release delay then starts over once the rails are good again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running supervisor clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_ok | input | 3 | Asynchronous rail-good indications: bit 0 core, bit 1 analog, bit 2 I/O bank |
| instant_on | input | 1 | Selects the short release delay |
| por_n | output | 1 | Main reset, low while the device is held in reset |
| config_start | output | 1 | One-cycle pulse when configuration may begin |
| io_tristate | output | 1 | High while outputs must stay tri-stated |
| ramp_fail | output | 1 | Sticky flag for a ramp-time violation |
| io_rail_drop | output | 1 | Sticky flag for an I/O-rail dip inside the observation window |

## Verification
Some properties are checked by assertions on every cycle. These are the one-cycle shape of `config_start` and its alignment with the rise of `por_n`, the complementary relation between `io_tristate` and `por_n`, and the stickiness of both flags. They also cover the fact that a synchronized core or analog low in user mode is followed by reset, while an I/O low is not.

The remaining behaviour can only be shown by the bench's scenarios. This includes the exact edge counts: two synchronizer stages, the ramp-budget boundary swept across every arrival cycle, the long and short release delays, the restart of the ramp timer after a brown-out, and the first and last edge of the I/O observation window.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
  localparam int RAIL_CORE = 0;
  localparam int RAIL_ANA  = 1;
  localparam int RAIL_IO   = 2;
  localparam int NUM_RAILS = 3;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,  // waiting for all rails, ramp timer running
    ST_HOLD = 2'd1,  // all rails good, release delay running
    ST_USER = 2'd2,  // reset released
    ST_FAIL = 2'd3   // ramp budget missed, held until rst
  } por_state_e;
endpackage

// File: rtl/por_rail_sync.sv
module por_rail_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] stage1;

  for (genvar g = 0; g < N; g++) begin : g_rail
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[g]   <= 1'b0;
        sync_out[g] <= 1'b0;
      end else begin
        stage1[g]   <= async_in[g];
        sync_out[g] <= stage1[g];
      end
    end
  end
endmodule

// File: rtl/por_sat_counter.sv
module por_sat_counter #(
  parameter int LIMIT = 16,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (en && count != TOP) begin
      count <= count + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= TOP);  // R5
endmodule

// File: rtl/por_io_watch.sv
module por_io_watch #(
  parameter int IOWIN_CYC = 64,
  localparam int WW = $clog2(IOWIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic io_good,
  output logic drop_flag
);
  localparam logic [WW-1:0] WIN_END = WW'(IOWIN_CYC);

  logic          armed;
  logic [WW-1:0] win_cnt;
  logic          win_open;

  assign win_open = armed && (win_cnt < WIN_END);

  por_sat_counter #(.LIMIT(IOWIN_CYC)) u_win_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (arm),
    .en   (win_open),
    .count(win_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      drop_flag <= 1'b0;
    end else begin
      if (arm) armed <= 1'b1;
      if (win_open && !arm && !io_good) drop_flag <= 1'b1;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    drop_flag |=> drop_flag);  // R8
  AST_FLAG_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(drop_flag) |-> $past(win_open));  // R8
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
  import por_seq_pkg::*;
#(
  parameter int RAMP_CYC  = 100000,
  parameter int REL_CYC   = 20000,
  parameter int FAST_CYC  = 64,
  parameter int IOWIN_CYC = 90000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rail_ok,
  input  logic       instant_on,
  output logic       por_n,
  output logic       config_start,
  output logic       io_tristate,
  output logic       ramp_fail,
  output logic       io_rail_drop
);
  localparam int DLY_MAX = (REL_CYC > FAST_CYC) ? REL_CYC : FAST_CYC;
  localparam int RW = $clog2(RAMP_CYC + 1);
  localparam int DW = $clog2(DLY_MAX + 1);
  localparam logic [RW-1:0] RAMP_LAST = RW'(RAMP_CYC - 1);
  localparam logic [DW-1:0] REL_LAST  = DW'(REL_CYC - 1);
  localparam logic [DW-1:0] FAST_LAST = DW'(FAST_CYC - 1);

  logic [NUM_RAILS-1:0] rail_s;
  logic                 core_ana_good;
  logic                 all_good;
  por_state_e           state, nxt;
  logic [RW-1:0]        ramp_cnt;
  logic [DW-1:0]        dly_cnt;
  logic [DW-1:0]        dly_last;
  logic                 brown_evt;
  logic                 arm_window;

  por_rail_sync #(.N(NUM_RAILS)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(rail_ok),
    .sync_out(rail_s)
  );

  assign core_ana_good = rail_s[RAIL_CORE] & rail_s[RAIL_ANA];
  assign all_good      = &rail_s;
  assign brown_evt     = (state == ST_USER) && !core_ana_good;
  assign dly_last      = instant_on ? FAST_LAST : REL_LAST;

  por_sat_counter #(.LIMIT(RAMP_CYC)) u_ramp_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (brown_evt),
    .en   (state == ST_WAIT),
    .count(ramp_cnt)
  );

  por_sat_counter #(.LIMIT(DLY_MAX)) u_dly_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (state != ST_HOLD),
    .en   (state == ST_HOLD),
    .count(dly_cnt)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_WAIT: begin
        if (all_good)                  nxt = ST_HOLD;
        else if (ramp_cnt >= RAMP_LAST) nxt = ST_FAIL;
      end
      ST_HOLD: begin
        if (!core_ana_good)            nxt = ST_WAIT;
        else if (dly_cnt >= dly_last)  nxt = ST_USER;
      end
      ST_USER: begin
        if (!core_ana_good)            nxt = ST_WAIT;
      end
      ST_FAIL:                         nxt = ST_FAIL;
      default:                         nxt = ST_FAIL;
    endcase
  end

  assign arm_window = (state == ST_WAIT) && (nxt == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_WAIT;
      por_n        <= 1'b0;
      io_tristate  <= 1'b1;
      config_start <= 1'b0;
      ramp_fail    <= 1'b0;
    end else begin
      state        <= nxt;
      por_n        <= (nxt == ST_USER);
      io_tristate  <= (nxt != ST_USER);
      config_start <= (state == ST_HOLD) && (nxt == ST_USER);
      ramp_fail    <= ramp_fail | (nxt == ST_FAIL);
    end
  end

  por_io_watch #(.IOWIN_CYC(IOWIN_CYC)) u_io_watch (
    .clk      (clk),
    .rst      (rst),
    .arm      (arm_window),
    .io_good  (rail_s[RAIL_IO]),
    .drop_flag(io_rail_drop)
  );

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    config_start |=> !config_start);  // R4
  AST_START_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    config_start |-> (por_n && !$past(por_n)));  // R4
  AST_RISE_NEEDS_RAILS: assert property (@(posedge clk) disable iff (rst)
    $rose(por_n) |-> $past(core_ana_good));  // R2
  AST_TRI_INVERSE: assert property (@(posedge clk) disable iff (rst)
    io_tristate == !por_n);  // R9
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    ramp_fail |=> ramp_fail);  // R5
  AST_FAIL_KEEPS_RESET: assert property (@(posedge clk) disable iff (rst)
    ramp_fail |-> !por_n);  // R5
  AST_BROWNOUT: assert property (@(posedge clk) disable iff (rst)
    (por_n && !core_ana_good) |=> !por_n);  // R6
  AST_IO_NO_RESET: assert property (@(posedge clk) disable iff (rst)
    (por_n && core_ana_good && !rail_s[RAIL_IO]) |=> por_n);  // R7
endmodule

// File: tb/por_sequencer_bench.sv
module por_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAMP  = 12;
  localparam int REL   = 9;
  localparam int FAST  = 2;
  localparam int IOWIN = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rail_ok = 3'b000;
  logic       instant_on = 1'b0;
  logic       por_n, config_start, io_tristate, ramp_fail, io_rail_drop;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  por_sequencer #(
    .RAMP_CYC(RAMP), .REL_CYC(REL), .FAST_CYC(FAST), .IOWIN_CYC(IOWIN)
  ) u_por_sequencer (
    .clk(clk), .rst(rst), .rail_ok(rail_ok), .instant_on(instant_on),
    .por_n(por_n), .config_start(config_start), .io_tristate(io_tristate),
    .ramp_fail(ramp_fail), .io_rail_drop(io_rail_drop)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Leaves the bench at a negedge with zero edges elapsed since reset release.
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rail_ok = 3'b000;
    step(2);
    check("R1 por_n in reset", por_n, 0);
    check("R1 io_tristate in reset", io_tristate, 1);
    rst = 1'b0;
  endtask

  // Counts edges until por_n is seen high; returns -1 on timeout.
  task automatic wait_por(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      step(1);
      if (por_n) begin
        n = i;
        break;
      end
    end
  endtask

  int n;
  int len;

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    step(1);
    check("R1 por_n", por_n, 0);
    check("R1 io_tristate", io_tristate, 1);
    check("R1 config_start", config_start, 0);
    check("R1 ramp_fail", ramp_fail, 0);
    check("R1 io_rail_drop", io_rail_drop, 0);

    // R2 R3 R5: sweep the last-rail arrival over the whole ramp budget
    for (int k = 1; k <= RAMP; k++) begin
      instant_on = k[0];
      len = instant_on ? FAST : REL;
      do_reset();
      if (k > 1) rail_ok = 3'b001 << (k % 3);
      step(k - 1);
      rail_ok = 3'b111;
      if (k <= RAMP - 2) begin
        wait_por(RAMP + REL + 10, n);
        check($sformatf("R2/R3 release edges k=%0d inst=%0d", k, instant_on), n, 3 + len);
        check("R4 config_start at rise", config_start, 1);
        check("R9 io_tristate released", io_tristate, 0);
        check("R5 no ramp_fail", ramp_fail, 0);
        step(1);
        check("R4 config_start one cycle", config_start, 0);
      end else begin
        step(RAMP - k);
        check($sformatf("R5 ramp_fail before limit k=%0d", k), ramp_fail, 0);
        step(1);
        check($sformatf("R5 ramp_fail at limit k=%0d", k), ramp_fail, 1);
        step(6);
        check("R5 ramp_fail sticky", ramp_fail, 1);
        check("R5 por_n held", por_n, 0);
        check("R9 io_tristate held", io_tristate, 1);
      end
    end
    instant_on = 1'b0;

    // R6 R7: user-mode dips on each rail
    for (int r = 0; r < 3; r++) begin
      do_reset();
      rail_ok = 3'b111;
      wait_por(40, n);
      check("R2 power-up before dip", n, 3 + REL);
      step(5);
      rail_ok[r] = 1'b0;
      step(2);
      check($sformatf("R6 por_n still high rail=%0d", r), por_n, 1);
      step(1);
      if (r == 2) begin
        check("R7 io dip keeps por_n", por_n, 1);
        step(6);
        check("R7 io dip keeps por_n later", por_n, 1);
      end else begin
        check($sformatf("R6 brown-out por_n rail=%0d", r), por_n, 0);
        check("R9 io_tristate on brown-out", io_tristate, 1);
        if (r == 0) begin
          step(RAMP - 1);
          check("R6 ramp restart before limit", ramp_fail, 0);
          step(1);
          check("R6 ramp restart at limit", ramp_fail, 1);
        end else begin
          rail_ok[r] = 1'b1;
          wait_por(40, n);
          check("R6 re-sequence after brown-out", n, 3 + REL);
        end
      end
    end

    // R8: I/O window last edge (flagged) and first edge after (ignored)
    for (int c = 0; c < 2; c++) begin
      do_reset();
      rail_ok = 3'b111;
      step(IOWIN + c);
      rail_ok[2] = 1'b0;
      step(1);
      rail_ok[2] = 1'b1;
      step(3);
      check($sformatf("R8 window boundary case=%0d", c), io_rail_drop, (c == 0) ? 1 : 0);
      check("R7 por_n during io dip", por_n, 1);
      step(10);
      check("R8 flag sticky", io_rail_drop, (c == 0) ? 1 : 0);
    end
    do_reset();
    step(1);
    check("R1 flag cleared by reset", io_rail_drop, 0);

    // R10: analog dip during the release delay restarts the delay
    rail_ok = 3'b111;
    step(3);
    rail_ok[1] = 1'b0;
    step(1);
    rail_ok[1] = 1'b1;
    step(8);
    check("R10 no release at original time", por_n, 0);
    step(3);
    check("R10 no release one edge early", por_n, 0);
    step(1);
    check("R10 release after restarted delay", por_n, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule